// File: doc/BRIEF.md
# Temperature Conversion Sequencer

This block schedules temperature conversions for a sensor core. After reset it launches a conversion straight away and then keeps converting periodically at one of four rates picked by a two-bit rate field in the configuration word. Setting the sleep bit halts periodic conversion at once. While asleep, software can request a single conversion on demand through a single-shot bit. That bit reads back as 1 while its conversion runs.

The block owns the 16-bit configuration word. It keeps the fields that neighbouring blocks decode, fixes the reserved bits, and passes the alert flag through to the read-back value. It drives a stub converter interface: a one-cycle start pulse, a done strobe and a 16-bit two's-complement result. Each completed result is latched into the temperature register together with a one-cycle new-sample strobe. The alert block receives a one-cycle pulse on every entry into sleep.

All timing is expressed in clock cycles through parameters. The first conversion after each sleep entry is delayed by a further `SLEEP_EXTRA_CYC` cycles.

Top module: `temp_conv_sequencer`

## Requirements
- R1: Reset state: the temperature output reads 0x0000, the configuration read-back is 0x4080 with bit 5 equal to the alert flag input, and the single-shot bit reads 0. The converter start is asserted in the first cycle after reset.
- R2: In continuous mode, conversion starts are one-cycle pulses spaced by the rate period. With B = `RATE_BASE_CYC`, the rate field (bits 7:6) gives 32·B for code 00, 8·B for 01, 2·B for 10 and B for 11. A new rate takes effect from the next start.
- R3: A done strobe that arrives while a conversion is in flight loads the result into the temperature output in the next cycle, with a one-cycle new-sample pulse. A done strobe with no conversion in flight leaves the temperature output unchanged.
- R4: A write that sets the sleep bit (bit 8) stops periodic starts at once. A conversion in flight at that moment is discarded.
- R5: A write that clears the sleep bit resumes continuous conversion. With no entry delay pending, the first start comes in the second cycle after the write.
- R6: A write carrying single-shot (bit 15) = 1 and sleep = 1 starts one conversion. Bit 15 reads 1 from the next cycle until the result is latched and then reads 0. No further start follows while asleep.
- R7: A single-shot request in a write that leaves sleep at 0 is ignored. A request made while a single shot is running does not restart it.
- R8: The first launch after each sleep entry, whether single-shot or a resume, issues its start `SLEEP_EXTRA_CYC` cycles later than it otherwise would.
- R9: Bits 4:0 and 13 read 0 and bit 14 reads 1 whatever is written. Bits 12:6 read back as written. Bit 5 mirrors the alert flag input.
- R10: A sleep-entry pulse lasts one cycle and follows only a 0→1 change of the sleep bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 16 | Configuration write data |
| alert_bit_i | input | 1 | Alert flag from the alert block, shown at bit 5 |
| cfg_rdata_o | output | 16 | Configuration read-back |
| adc_start_o | output | 1 | One-cycle conversion start to the converter |
| adc_done_i | input | 1 | Converter done strobe |
| adc_result_i | input | 16 | Converter result, two's complement |
| temp_o | output | 16 | Temperature register |
| new_sample_o | output | 1 | One-cycle pulse when the temperature register is loaded |
| ss_busy_o | output | 1 | Live single-shot status |
| sleep_enter_o | output | 1 | One-cycle pulse on entry into sleep |

## Verification
For a write at clock edge w, the configuration read-back, the single-shot status and the sleep-entry pulse are all due right after edge w. A start launched directly by that write is also due after edge w. A start delayed by the sleep-entry penalty is due after edge w+`SLEEP_EXTRA_CYC`. A resume from sleep costs one more edge. A done strobe seen at an edge shows up in the temperature output after that same edge. A behavioural model in the bench advances on each rising edge using the inputs that were driven one nanosecond after the previous edge, and it is compared with every output at the falling edge. Directed checks count falling edges from the end of a write to the first start, and record start timestamps to measure the rate periods.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int unsigned CFG_W     = 16;
  localparam int unsigned SS_BIT    = 15;
  localparam int unsigned SM_BIT    = 8;
  localparam int unsigned FIELD_LSB = 6;
  localparam int unsigned FIELD_W   = 7;

  typedef struct packed {
    logic [1:0] cf;
    logic       pol;
    logic       im;
    logic       sm;
    logic [1:0] cr;
  } cfg_fields_t;

  localparam cfg_fields_t CFG_RESET = '{cf: 2'b00, pol: 1'b0, im: 1'b0, sm: 1'b0, cr: 2'b10};

  // period multiple of the fastest rate for each rate code
  function automatic int unsigned rate_mult(input int unsigned code);
    case (code)
      0:       return 32;
      1:       return 8;
      2:       return 2;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/tcs_cfg_reg.sv
module tcs_cfg_reg
  import tcs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_W-1:0]  wdata_i,
  input  logic              alert_bit_i,
  input  logic              ss_i,
  output cfg_fields_t       fields_o,
  output logic              enter_o,
  output logic              leave_o,
  output logic              ss_req_o,
  output logic              sleep_enter_o,
  output logic [CFG_W-1:0]  rdata_o
);
  cfg_fields_t fields_q;
  logic        se_q;

  assign enter_o  = we_i && wdata_i[SM_BIT] && !fields_q.sm;
  assign leave_o  = we_i && !wdata_i[SM_BIT] && fields_q.sm;
  // single shot only when the same write leaves sleep set
  assign ss_req_o = we_i && wdata_i[SS_BIT] && wdata_i[SM_BIT] && !ss_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fields_q <= CFG_RESET;
      se_q     <= 1'b0;
    end else begin
      se_q <= enter_o;
      if (we_i) fields_q <= cfg_fields_t'(wdata_i[FIELD_LSB +: FIELD_W]);
    end
  end

  assign fields_o      = fields_q;
  assign sleep_enter_o = se_q;
  assign rdata_o       = {ss_i, 1'b1, 1'b0, fields_q, alert_bit_i, 5'b00000};
endmodule

// File: rtl/tcs_rate_timer.sv
module tcs_rate_timer
  import tcs_pkg::*;
#(
  parameter int unsigned RATE_BASE_CYC = 1250
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] cr_i,
  input  logic       reload_i,
  input  logic       expire_now_i,
  output logic       expired_o
);
  localparam int unsigned MAX_PER = 32 * RATE_BASE_CYC;
  localparam int unsigned PW      = $clog2(MAX_PER + 1);

  logic [PW-1:0] per_tab [4];
  logic [PW-1:0] cnt_q;

  for (genvar g = 0; g < 4; g++) begin : g_tab
    assign per_tab[g] = PW'(rate_mult(g) * RATE_BASE_CYC - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= PW'(rate_mult(int'(CFG_RESET.cr)) * RATE_BASE_CYC - 1);
    end else if (expire_now_i) begin
      cnt_q <= '0;
    end else if (reload_i) begin
      cnt_q <= per_tab[cr_i];
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/tcs_conv_ctrl.sv
module tcs_conv_ctrl
  import tcs_pkg::*;
#(
  parameter int unsigned SLEEP_EXTRA_CYC = 600
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sm_i,
  input  logic              enter_i,
  input  logic              ss_req_i,
  input  logic              expired_i,
  input  logic              adc_done_i,
  input  logic [CFG_W-1:0]  adc_result_i,
  output logic              reload_o,
  output logic              start_o,
  output logic [CFG_W-1:0]  temp_o,
  output logic              new_o,
  output logic              ss_o
);
  localparam int unsigned DW = $clog2(SLEEP_EXTRA_CYC + 1);
  localparam logic [DW-1:0] DLY_LOAD = DW'(SLEEP_EXTRA_CYC - 1);

  logic             start_q, busy_q, dly_q, pend_q, ss_q, new_q;
  logic [DW-1:0]    dly_cnt_q;
  logic [CFG_W-1:0] temp_q;
  logic             launch, dly_end, issue;

  always_comb begin
    launch = 1'b0;
    if (!enter_i) begin
      if (sm_i) launch = ss_req_i;
      else      launch = expired_i && !busy_q && !dly_q;
    end
    dly_end = dly_q && (dly_cnt_q == '0) && !enter_i;
    issue   = (launch && !pend_q) || dly_end;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q   <= 1'b1;  // conversion fires straight out of reset
      busy_q    <= 1'b1;
      dly_q     <= 1'b0;
      pend_q    <= 1'b0;
      ss_q      <= 1'b0;
      new_q     <= 1'b0;
      dly_cnt_q <= '0;
      temp_q    <= '0;
    end else begin
      start_q <= issue;
      new_q   <= 1'b0;
      if (enter_i) begin
        busy_q    <= 1'b0;  // in-flight result dropped
        dly_q     <= ss_req_i;
        dly_cnt_q <= DLY_LOAD;
        pend_q    <= !ss_req_i;
        ss_q      <= ss_req_i;
      end else begin
        if (busy_q && adc_done_i) begin
          temp_q <= adc_result_i;
          new_q  <= 1'b1;
          busy_q <= 1'b0;
          ss_q   <= 1'b0;
        end
        if (sm_i && ss_req_i) ss_q <= 1'b1;
        if (launch && pend_q) begin
          dly_q     <= 1'b1;
          dly_cnt_q <= DLY_LOAD;
          pend_q    <= 1'b0;
        end else if (dly_q) begin
          if (dly_cnt_q == '0) dly_q <= 1'b0;
          else                 dly_cnt_q <= dly_cnt_q - 1'b1;
        end
        if (issue) busy_q <= 1'b1;
      end
    end
  end

  assign reload_o = issue;
  assign start_o  = start_q;
  assign temp_o   = temp_q;
  assign new_o    = new_q;
  assign ss_o     = ss_q;
endmodule

// File: rtl/temp_conv_sequencer.sv
module temp_conv_sequencer
  import tcs_pkg::*;
#(
  parameter int unsigned RATE_BASE_CYC   = 1250,
  parameter int unsigned SLEEP_EXTRA_CYC = 600
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [15:0] cfg_wdata_i,
  input  logic        alert_bit_i,
  output logic [15:0] cfg_rdata_o,
  output logic        adc_start_o,
  input  logic        adc_done_i,
  input  logic [15:0] adc_result_i,
  output logic [15:0] temp_o,
  output logic        new_sample_o,
  output logic        ss_busy_o,
  output logic        sleep_enter_o
);
  cfg_fields_t fields;
  logic enter, leave, ss_req, ss, expired, reload;

  tcs_cfg_reg u_cfg (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .we_i          (cfg_we_i),
    .wdata_i       (cfg_wdata_i),
    .alert_bit_i   (alert_bit_i),
    .ss_i          (ss),
    .fields_o      (fields),
    .enter_o       (enter),
    .leave_o       (leave),
    .ss_req_o      (ss_req),
    .sleep_enter_o (sleep_enter_o),
    .rdata_o       (cfg_rdata_o)
  );

  tcs_rate_timer #(.RATE_BASE_CYC(RATE_BASE_CYC)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cr_i         (fields.cr),
    .reload_i     (reload),
    .expire_now_i (leave),
    .expired_o    (expired)
  );

  tcs_conv_ctrl #(.SLEEP_EXTRA_CYC(SLEEP_EXTRA_CYC)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sm_i         (fields.sm),
    .enter_i      (enter),
    .ss_req_i     (ss_req),
    .expired_i    (expired),
    .adc_done_i   (adc_done_i),
    .adc_result_i (adc_result_i),
    .reload_o     (reload),
    .start_o      (adc_start_o),
    .temp_o       (temp_o),
    .new_o        (new_sample_o),
    .ss_o         (ss)
  );

  assign ss_busy_o = ss;
endmodule

// File: rtl/temp_conv_sequencer_chk.sv
module temp_conv_sequencer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_we_i,
  input logic [15:0] cfg_rdata_o,
  input logic        adc_start_o,
  input logic        adc_done_i,
  input logic [15:0] temp_o,
  input logic        new_sample_o,
  input logic        ss_busy_o,
  input logic        sleep_enter_o
);
  assert_start_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |=> !adc_start_o);

  assert_sample_after_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_sample_o |-> $past(adc_done_i));

  assert_temp_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !new_sample_o |-> $stable(temp_o));

  assert_no_start_asleep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[8] && !ss_busy_o) |-> !adc_start_o);

  assert_ss_rise_on_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ss_busy_o) |-> $past(cfg_we_i));

  assert_ss_fall_with_sample_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ss_busy_o) |-> new_sample_o);

  assert_sleep_pulse_edge_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_enter_o |-> (cfg_rdata_o[8] && !$past(cfg_rdata_o[8])));

  assert_sleep_pulse_len_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_enter_o |=> !sleep_enter_o);
endmodule

bind temp_conv_sequencer temp_conv_sequencer_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_we_i      (cfg_we_i),
  .cfg_rdata_o   (cfg_rdata_o),
  .adc_start_o   (adc_start_o),
  .adc_done_i    (adc_done_i),
  .temp_o        (temp_o),
  .new_sample_o  (new_sample_o),
  .ss_busy_o     (ss_busy_o),
  .sleep_enter_o (sleep_enter_o)
);

// File: tb/temp_conv_sequencer_test.sv
`timescale 1ns/1ps
module temp_conv_sequencer_test;
  localparam int BASE  = 16;
  localparam int EXTRA = 10;
  localparam int CONV  = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [15:0] cfg_wdata_i = '0;
  logic        alert_bit_i = 1'b0;
  logic [15:0] cfg_rdata_o;
  logic        adc_start_o;
  logic        adc_done_i = 1'b0;
  logic [15:0] adc_result_i = '0;
  logic [15:0] temp_o;
  logic        new_sample_o;
  logic        ss_busy_o;
  logic        sleep_enter_o;

  temp_conv_sequencer #(.RATE_BASE_CYC(BASE), .SLEEP_EXTRA_CYC(EXTRA)) uut (.*);

  always #5 clk_i = ~clk_i;

  int n_tests = 0, n_fail = 0, ncyc = 0;
  bit finished = 0, live = 0, inject = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, ncyc);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // stub converter: done CONV cycles after a start
  int cd = -1;
  logic [15:0] res_next = 16'hFF80, last_res = '0;
  always @(posedge clk_i) begin
    #1;
    adc_done_i = 1'b0;
    if (cd > 0) cd--;
    if (cd == 0) begin
      adc_done_i = 1'b1; adc_result_i = res_next; last_res = res_next;
      res_next = res_next + 16'h0137; cd = -1;
    end
    if (inject) begin adc_done_i = 1'b1; adc_result_i = 16'hDEAD; inject = 0; end
    if (adc_start_o) cd = CONV;
  end

  // behavioural reference
  bit m_start, m_busy, m_dly, m_pend, m_ss, m_new, m_se;
  int m_per, m_dcnt;
  logic [15:0] m_temp;
  logic [6:0]  m_fld;

  function automatic int per_of(input logic [1:0] c);
    case (c)
      2'd0: return 32 * BASE;
      2'd1: return 8 * BASE;
      2'd2: return 2 * BASE;
      default: return BASE;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin : model
    bit wr, o_sm, ent, lv, ssr, o_busy, o_dly, o_pend, fire, lnch;
    int o_cnt, o_per;
    logic [15:0] d;
    logic [1:0] o_cr;
    if (!rst_ni) begin
      m_start = 1; m_busy = 1; m_dly = 0; m_pend = 0; m_ss = 0; m_new = 0; m_se = 0;
      m_per = per_of(2'b10) - 1; m_dcnt = 0; m_temp = 0; m_fld = 7'b0000010;
    end else begin
      wr = cfg_we_i; d = cfg_wdata_i; o_sm = m_fld[2]; o_cr = m_fld[1:0];
      ent = wr && d[8] && !o_sm; lv = wr && !d[8] && o_sm;
      ssr = wr && d[15] && d[8] && !m_ss;
      o_busy = m_busy; o_dly = m_dly; o_pend = m_pend; o_cnt = m_dcnt; o_per = m_per;
      fire = 0; lnch = 0;
      m_start = 0; m_new = 0; m_se = ent;
      if (o_per > 0) m_per = o_per - 1;
      if (ent) begin
        m_busy = 0; m_dly = ssr; m_dcnt = EXTRA - 1; m_pend = !ssr; m_ss = ssr;
      end else begin
        if (o_busy && adc_done_i) begin
          m_temp = adc_result_i; m_new = 1; m_busy = 0; m_ss = 0;
        end
        if (o_sm) begin
          if (ssr) begin m_ss = 1; lnch = 1; end
        end else if (o_per == 0 && !o_busy && !o_dly) lnch = 1;
        if (lnch && o_pend) begin
          m_dly = 1; m_dcnt = EXTRA - 1; m_pend = 0;
        end else begin
          if (lnch) fire = 1;
          if (o_dly) begin
            if (o_cnt == 0) begin m_dly = 0; fire = 1; end
            else m_dcnt = o_cnt - 1;
          end
        end
      end
      if (fire) begin m_start = 1; m_busy = 1; m_per = per_of(o_cr) - 1; end
      if (lv) m_per = 0;
      if (wr) m_fld = d[12:6];
    end
  end

  always @(negedge clk_i) begin
    ncyc++;
    if (live) begin
      check(adc_start_o === m_start, "R2 start", adc_start_o, m_start);
      check(temp_o === m_temp, "R3 temp", temp_o, m_temp);
      check(new_sample_o === m_new, "R3 new_sample", new_sample_o, m_new);
      check(ss_busy_o === m_ss, "R6 ss_busy", ss_busy_o, m_ss);
      check(sleep_enter_o === m_se, "R10 sleep_enter", sleep_enter_o, m_se);
      check(cfg_rdata_o === {m_ss, 2'b10, m_fld, alert_bit_i, 5'b0}, "R9 cfg_rdata",
            cfg_rdata_o, {m_ss, 2'b10, m_fld, alert_bit_i, 5'b0});
      if (new_sample_o) check(temp_o === last_res, "R3 latched value", temp_o, last_res);
    end
    if (ncyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", ncyc);
      summary();
    end
  end

  task automatic wr(input logic [15:0] d);
    @(posedge clk_i); #1;
    cfg_we_i = 1'b1; cfg_wdata_i = d;
    @(posedge clk_i); #1;
    cfg_we_i = 1'b0;
  endtask

  task automatic wait_start(output int t);
    @(negedge clk_i);
    while (!adc_start_o) @(negedge clk_i);
    t = ncyc;
  endtask

  task automatic lat_to_start(output int k);
    k = 0;
    @(negedge clk_i);
    while (!adc_start_o && k < 5000) begin k++; @(negedge clk_i); end
  endtask

  task automatic measure_period(input int exp, input string req);
    int t0, t1, t2;
    wait_start(t0); wait_start(t1); wait_start(t2);
    check(t2 - t1 == exp, req, t2 - t1, exp);
  endtask

  task automatic count_starts(input int cyc, output int n);
    n = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk_i);
      if (adc_start_o) n++;
    end
  endtask

  initial begin
    int k, n;
    logic [15:0] tsave;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    check(adc_start_o === 1'b1, "R1 start after reset", adc_start_o, 1);
    check(temp_o === 16'h0000, "R1 temp reset", temp_o, 0);
    check(cfg_rdata_o === 16'h4080, "R1 cfg reset", cfg_rdata_o, 16'h4080);
    check(ss_busy_o === 1'b0, "R1 ss reset", ss_busy_o, 0);
    live = 1;

    measure_period(2 * BASE, "R2 rate 10");
    wr(16'h00C0); measure_period(BASE, "R2 rate 11");
    wr(16'h0040); measure_period(8 * BASE, "R2 rate 01");
    wr(16'h0000); measure_period(32 * BASE, "R2 rate 00");
    wr(16'h0080); measure_period(2 * BASE, "R2 rate 10 again");

    // R4: sleep entry during a conversion
    wait_start(k);
    tsave = temp_o;
    wr(16'h0180);
    @(negedge clk_i);
    check(sleep_enter_o === 1'b1, "R10 pulse on entry", sleep_enter_o, 1);
    count_starts(300, n);
    check(n == 0, "R4 no starts asleep", n, 0);
    check(temp_o === tsave, "R4 in-flight result dropped", temp_o, tsave);
    inject = 1;
    repeat (3) @(negedge clk_i);
    check(temp_o === tsave, "R3 stray done ignored", temp_o, tsave);
    wr(16'h0180);
    count_starts(3, n);
    check(sleep_enter_o === 1'b0, "R10 no pulse when already asleep", sleep_enter_o, 0);

    // R8/R6: first single shot after entry is delayed
    alert_bit_i = 1'b1;
    wr(16'h8180);
    check(ss_busy_o === 1'b1, "R6 ss reads busy", ss_busy_o, 1);
    lat_to_start(k);
    check(k == EXTRA, "R8 extra delay single shot", k, EXTRA);
    while (ss_busy_o) @(negedge clk_i);
    check(new_sample_o === 1'b1, "R6 ss clears with sample", new_sample_o, 1);
    count_starts(200, n);
    check(n == 0, "R6 stays asleep", n, 0);
    wr(16'h8180);
    lat_to_start(k);
    check(k == 0, "R8 no delay on second single shot", k, 0);
    wr(16'h8180);
    count_starts(30, n);
    check(n == 0, "R7 no restart during single shot", n, 0);
    check(ss_busy_o === 1'b0, "R6 ss done", ss_busy_o, 0);

    // R9 + R5: reserved bits, leave sleep with nothing pending
    wr(16'h3EDF);
    check(cfg_rdata_o === 16'h5EE0, "R9 reserved fixed", cfg_rdata_o, 16'h5EE0);
    lat_to_start(k);
    check(k == 1, "R5 resume latency", k, 1);
    measure_period(BASE, "R2 rate after resume");
    wr(16'h80C0);
    check(ss_busy_o === 1'b0, "R7 ss ignored awake", ss_busy_o, 0);
    check(cfg_rdata_o[15] === 1'b0, "R7 ss bit stays 0", cfg_rdata_o[15], 0);

    // R8: resume with the entry delay still pending
    wr(16'h0180);
    repeat (20) @(negedge clk_i);
    wr(16'h00C0);
    lat_to_start(k);
    check(k == EXTRA + 1, "R8 extra delay on resume", k, EXTRA + 1);
    repeat (100) @(negedge clk_i);
    summary();
  end
endmodule